// File: doc/BRIEF.md
# Key Matrix Scanner with Supervisor Keep-Alive

This block scans a key matrix of five column lines and three row lines and reports key presses and releases as events on a valid/ready stream. It drives one column low at a time and samples the active-low row lines near the end of that column's slot. A full pass over all columns is one frame. A key must be seen alone, in the same position, for several consecutive frames before a press or release event is produced. Frames in which more than one key reads as pressed are discarded.

One of the column lines also feeds an external power supervisor. That supervisor removes power unless it receives a positive pulse about once per second. After the last column slot of every frame the scanner adds a gap slot in which no column is scanned. When the keep-alive period has run out, the scanner draws the pulse on the shared column inside the next gap: low, then high, then low, then back to its idle high level. Because the pulse only ever appears inside the gap, it cannot be confused with a key scan and never overlaps a column driven low. Raising the power-off request stops all further pulses until reset. The supervisor then times out and cuts the supply, while scanning carries on up to that point.

Event stream rules: `key_valid_o` rises with a code and holds both the code and valid until `key_ready_i` is high at a clock edge. While an event waits, no later event replaces it. Key changes that happen during the wait are kept in the debounce state and delivered after the handshake. The slot length and the keep-alive period are derived from the system clock frequency parameter, which defaults to 3.6864 MHz.

Top module: `keypad_wdog_scanner`

## Requirements
- R1: While reset is asserted, all column outputs are high and `key_valid_o` is low.
- R2: Each frame is NUM_COLS column slots followed by one gap slot, each SLOT = CLK_HZ/COL_RATE_HZ cycles long. In column slot k only column k is low and all other columns are high. The columns are scanned in ascending order, starting with column 0 right after reset. In a gap without a pulse, all columns are high.
- R3: A row input reading low while column c is driven low means the key at row r, column c is pressed. The event code is bit 5 = 1 for a press and 0 for a release, bits 4:3 = row, and bits 2:0 = column.
- R4: A press event is produced only after the same single key has been seen in DEB_SCANS consecutive frames (default 3). A key held for fewer frames produces no event.
- R5: A release event, carrying the released key's row and column, is produced after DEB_SCANS consecutive frames with no key pressed.
- R6: If one key is exchanged directly for another, a release of the old key is produced first, followed by a press of the new key in a later frame.
- R7: A frame in which more than one key reads as pressed neither produces an event nor advances or resets the debounce count.
- R8: Each keep-alive pulse takes place on column KICK_COL inside one gap slot. Within that gap the column is high for KICK_W cycles, low for KICK_W, high for KICK_W, low for KICK_W, and then high. Consecutive pulses are separated by CLK_HZ/KICK_HZ cycles, give or take one frame.
- R9: At no time is more than one column low, and the keep-alive pulse is drawn only inside the gap slot.
- R10: Once the power-off request has been high at a clock edge, no further keep-alive pulse is drawn until reset. Key scanning and key events continue.
- R11: While `key_valid_o` is high and `key_ready_i` is low, `key_valid_o` stays high and `key_code_o` does not change. Key changes that occur during the stall are reported after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_n_i | input | NUM_ROWS | Row sense lines, pulled up, low when a key connects them to a low column |
| col_o | output | NUM_COLS | Column drive lines, active low; column KICK_COL also carries the keep-alive pulse |
| pwr_off_req_i | input | 1 | Power-off request; stops keep-alive pulses until reset |
| key_valid_o | output | 1 | Event code valid |
| key_ready_i | input | 1 | Consumer accepts the event at this clock edge |
| key_code_o | output | 6 | Event code: press flag, row, column |

## Verification
The main scanning function is exercised with several input patterns:
- Single keys in different rows and columns, including a key on the shared keep-alive column. These show that row and column are decoded correctly.
- A press shorter than two frames. This separates a proper frame debounce from a simple edge detector.
- Two keys held together. This shows that frames with more than one key are discarded rather than reported as one of the keys.
- A direct exchange of one key for another. This checks that a release of the old key is produced before the press of the new one.

The keep-alive pulse is checked through its shape on the shared column, its spacing, and its absence after a power-off request. A stalled consumer is used to show that the pending code is held and that a later release is still delivered once the stall ends.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_ROW_W = 2;
  localparam int KP_COL_W = 3;
  localparam int KP_CODE_W = 1 + KP_ROW_W + KP_COL_W;

  typedef struct packed {
    logic                hit;
    logic [KP_ROW_W-1:0] row;
    logic [KP_COL_W-1:0] col;
  } kp_key_t;

  typedef enum logic {
    EV_RELEASE = 1'b0,
    EV_PRESS   = 1'b1
  } kp_ev_e;
endpackage

// File: rtl/kp_col_sched.sv
module kp_col_sched #(
  parameter int NUM_COLS    = 5,
  parameter int SLOT_CYC    = 3686,
  parameter int KICK_PERIOD = 3686400,
  parameter int KICK_W      = 64,
  parameter int KICK_COL    = 2,
  localparam int SLOT_W     = $clog2(SLOT_CYC),
  localparam int IDX_W      = $clog2(NUM_COLS + 1),
  localparam int KT_W       = $clog2(KICK_PERIOD)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_off_req_i,
  output logic [NUM_COLS-1:0] col_o,
  output logic                smp_o,
  output logic [IDX_W-1:0]    smp_col_o,
  output logic                frame_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYC - 1);
  localparam logic [IDX_W-1:0]  GAP_IDX   = IDX_W'(NUM_COLS);
  localparam logic [KT_W-1:0]   KT_LAST   = KT_W'(KICK_PERIOD - 1);

  logic [SLOT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]    idx_q;
  logic [KT_W-1:0]     ktmr_q;
  logic                due_q, kick_on_q, off_q;
  logic [NUM_COLS-1:0] col_q, col_nx;
  logic                slot_end, enter_gap, kt_wrap, off_now;

  assign slot_end  = (cnt_q == SLOT_LAST);
  assign enter_gap = (idx_q == GAP_IDX - 1'b1) && slot_end;
  assign kt_wrap   = (ktmr_q == KT_LAST);
  assign off_now   = off_q || pwr_off_req_i;

  always_comb begin
    col_nx = '1;
    if (idx_q < GAP_IDX) begin
      col_nx[idx_q] = 1'b0;
    end else if (kick_on_q) begin
      if (((32'(cnt_q) >= KICK_W) && (32'(cnt_q) < 2*KICK_W)) ||
          ((32'(cnt_q) >= 3*KICK_W) && (32'(cnt_q) < 4*KICK_W)))
        col_nx[KICK_COL] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      idx_q     <= '0;
      ktmr_q    <= '0;
      due_q     <= 1'b0;
      kick_on_q <= 1'b0;
      off_q     <= 1'b0;
      col_q     <= '1;
    end else begin
      col_q  <= col_nx;
      off_q  <= off_now;
      ktmr_q <= kt_wrap ? '0 : ktmr_q + 1'b1;
      if (slot_end) begin
        cnt_q <= '0;
        idx_q <= (idx_q == GAP_IDX) ? '0 : idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      due_q <= enter_gap ? 1'b0 : (due_q | kt_wrap);
      if (off_now)
        kick_on_q <= 1'b0;
      else if (enter_gap && (due_q || kt_wrap))
        kick_on_q <= 1'b1;
      else if ((idx_q == GAP_IDX) && slot_end)
        kick_on_q <= 1'b0;
    end
  end

  assign col_o     = col_q;
  assign smp_o     = (idx_q < GAP_IDX) && slot_end;
  assign smp_col_o = idx_q;
  assign frame_o   = (idx_q == GAP_IDX) && (cnt_q == '0);

  // R9: never two columns low at once
  p_one_col_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~col_q) <= 1);
  // R9: pulse state only lives in the gap slot
  p_kick_in_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick_on_q |-> (idx_q == GAP_IDX));
  // R10: no pulse once power-off has been seen
  p_no_kick_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> !kick_on_q);
  // R10: power-off stays latched
  p_off_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |=> off_q);
endmodule

// File: rtl/kp_row_cap.sv
module kp_row_cap
  import kp_pkg::*;
#(
  parameter int NUM_COLS = 5,
  parameter int NUM_ROWS = 3,
  localparam int IDX_W   = $clog2(NUM_COLS + 1),
  localparam int HIT_W   = $clog2(NUM_COLS * NUM_ROWS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ROWS-1:0] row_n_i,
  input  logic                smp_i,
  input  logic [IDX_W-1:0]    smp_col_i,
  input  logic                frame_i,
  output logic                fr_valid_o,
  output kp_key_t             fr_key_o,
  output logic                fr_multi_o
);
  logic [NUM_ROWS-1:0]                s1_q, s2_q;
  logic [NUM_COLS-1:0][NUM_ROWS-1:0]  map_q;
  logic [HIT_W-1:0]                   hits;
  kp_key_t                            found;

  always_comb begin
    hits  = '0;
    found = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        if (map_q[c][r]) begin
          hits      = hits + 1'b1;
          found.row = KP_ROW_W'(r);
          found.col = KP_COL_W'(c);
        end
      end
    end
    found.hit = (hits == HIT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= row_n_i;
      s2_q <= s1_q;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[c] <= '0;
      else if (frame_i)
        map_q[c] <= '0;
      else if (smp_i && (smp_col_i == IDX_W'(c)))
        map_q[c] <= ~s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_valid_o <= 1'b0;
      fr_key_o   <= '0;
      fr_multi_o <= 1'b0;
    end else begin
      fr_valid_o <= frame_i;
      if (frame_i) begin
        fr_key_o   <= found;
        fr_multi_o <= (hits > HIT_W'(1));
      end
    end
  end

  // R7: a multi-key frame never carries a single-key hit
  p_multi_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid_o |-> !(fr_multi_o && fr_key_o.hit));
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce
  import kp_pkg::*;
#(
  parameter int DEB_SCANS = 3,
  localparam int CW       = $clog2(DEB_SCANS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fr_valid_i,
  input  kp_key_t              fr_key_i,
  input  logic                 fr_multi_i,
  input  logic                 ev_ready_i,
  output logic                 ev_valid_o,
  output logic [KP_CODE_W-1:0] ev_code_o
);
  localparam logic [CW-1:0] DEB_N = CW'(DEB_SCANS);

  kp_key_t                last_q, comm_q;
  logic [CW-1:0]          cnt_q, cnt_nx;
  logic                   ev_v_q, fire, take;
  logic [KP_CODE_W-1:0]   ev_c_q;

  assign take   = fr_valid_i && !fr_multi_i;
  assign cnt_nx = (fr_key_i == last_q) ? ((cnt_q == DEB_N) ? cnt_q : cnt_q + 1'b1)
                                       : CW'(1);
  assign fire   = take && (cnt_nx >= DEB_N) && (fr_key_i != comm_q) &&
                  (!ev_v_q || ev_ready_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      comm_q <= '0;
      cnt_q  <= '0;
      ev_v_q <= 1'b0;
      ev_c_q <= '0;
    end else begin
      if (take) begin
        last_q <= fr_key_i;
        cnt_q  <= cnt_nx;
      end
      if (fire) begin
        ev_v_q <= 1'b1;
        if (comm_q.hit) begin
          ev_c_q <= {EV_RELEASE, comm_q.row, comm_q.col};
          comm_q <= '0;
        end else begin
          ev_c_q <= {EV_PRESS, fr_key_i.row, fr_key_i.col};
          comm_q <= fr_key_i;
        end
      end else if (ev_ready_i) begin
        ev_v_q <= 1'b0;
      end
    end
  end

  assign ev_valid_o = ev_v_q;
  assign ev_code_o  = ev_c_q;

  // R11: stalled event holds
  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_v_q && !ev_ready_i) |=> (ev_v_q && $stable(ev_c_q)));
  // R4: a new event only follows a completed frame
  p_event_after_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_v_q) |-> $past(fr_valid_i));
endmodule

// File: rtl/keypad_wdog_scanner.sv
module keypad_wdog_scanner
  import kp_pkg::*;
#(
  parameter int NUM_COLS    = 5,
  parameter int NUM_ROWS    = 3,
  parameter int CLK_HZ      = 3686400,
  parameter int COL_RATE_HZ = 1000,
  parameter int KICK_HZ     = 1,
  parameter int KICK_W      = 64,
  parameter int KICK_COL    = 2,
  parameter int DEB_SCANS   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_ROWS-1:0]  row_n_i,
  output logic [NUM_COLS-1:0]  col_o,
  input  logic                 pwr_off_req_i,
  output logic                 key_valid_o,
  input  logic                 key_ready_i,
  output logic [KP_CODE_W-1:0] key_code_o
);
  localparam int SLOT_CYC    = CLK_HZ / COL_RATE_HZ;
  localparam int KICK_PERIOD = CLK_HZ / KICK_HZ;
  localparam int IDX_W       = $clog2(NUM_COLS + 1);

  logic             smp, frame, fr_valid, fr_multi;
  logic [IDX_W-1:0] smp_col;
  kp_key_t          fr_key;

  kp_col_sched #(
    .NUM_COLS(NUM_COLS), .SLOT_CYC(SLOT_CYC), .KICK_PERIOD(KICK_PERIOD),
    .KICK_W(KICK_W), .KICK_COL(KICK_COL)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .pwr_off_req_i(pwr_off_req_i),
    .col_o(col_o), .smp_o(smp), .smp_col_o(smp_col), .frame_o(frame)
  );

  kp_row_cap #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_cap (
    .clk(clk), .rst_n(rst_n), .row_n_i(row_n_i), .smp_i(smp),
    .smp_col_i(smp_col), .frame_i(frame), .fr_valid_o(fr_valid),
    .fr_key_o(fr_key), .fr_multi_o(fr_multi)
  );

  kp_debounce #(.DEB_SCANS(DEB_SCANS)) u_deb (
    .clk(clk), .rst_n(rst_n), .fr_valid_i(fr_valid), .fr_key_i(fr_key),
    .fr_multi_i(fr_multi), .ev_ready_i(key_ready_i),
    .ev_valid_o(key_valid_o), .ev_code_o(key_code_o)
  );
endmodule

// File: tb/keypad_wdog_scanner_tb_top.sv
module keypad_wdog_scanner_tb_top;
  localparam int NC = 5, NR = 3, KW = 2, KC = 2;
  localparam int SLOT = 10, FRAME = 60, PER = 750;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] row_n;
  logic [NC-1:0] col;
  logic          pwr_off = 1'b0;
  logic          ev_ready = 1'b1;
  logic          ev_valid;
  logic [5:0]    ev_code;
  logic [NC-1:0][NR-1:0] keys = '0;

  int total = 0, bad = 0;
  int cyc = 0, run = 0, halves = 0, kicks = 0, viol = 0, nlog = 0;
  int ktime [0:63];
  logic [5:0] evlog [0:255];

  always #10 clk = ~clk;

  keypad_wdog_scanner #(
    .NUM_COLS(NC), .NUM_ROWS(NR), .CLK_HZ(750), .COL_RATE_HZ(75),
    .KICK_HZ(1), .KICK_W(KW), .KICK_COL(KC), .DEB_SCANS(3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .row_n_i(row_n), .col_o(col),
    .pwr_off_req_i(pwr_off), .key_valid_o(ev_valid),
    .key_ready_i(ev_ready), .key_code_o(ev_code)
  );

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      row_n[r] = 1'b1;
      for (int c = 0; c < NC; c++)
        if (keys[c][r] && !col[c]) row_n[r] = 1'b0;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (ev_valid && ev_ready) begin
        evlog[nlog[7:0]] = ev_code;
        nlog = nlog + 1;
      end
      if ($countones(~col) > 1) viol = viol + 1;
      if (!col[KC]) run = run + 1;
      else begin
        if (run == KW) begin
          halves = halves + 1;
          if (halves % 2 == 0) begin
            ktime[kicks[5:0]] = cyc;
            kicks = kicks + 1;
          end
        end
        run = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setkey(input int r, input int c, input bit v);
    @(posedge clk); #1;
    keys[c][r] = v;
  endtask

  task automatic wait_ev(input int lim, output bit got, output logic [5:0] code);
    int n0 = nlog;
    got = 0; code = '0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (nlog > n0) begin got = 1; code = evlog[n0[7:0]]; break; end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(col == '1, "R1 columns high", int'(col), 31);
    chk(!ev_valid, "R1 valid low", int'(ev_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic t_scan;
    int errs;
    for (int i = 0; i < 40 && col[0]; i++) @(negedge clk);
    for (int k = 0; k <= NC; k++) begin
      logic [NC-1:0] exp;
      exp = (k < NC) ? ~(NC'(1) << k) : '1;
      errs = 0;
      for (int i = 0; i < SLOT; i++) begin
        if (col != exp) errs++;
        if (i < SLOT - 1) @(negedge clk);
      end
      chk(errs == 0, "R2 slot pattern", int'(col), int'(exp));
      @(negedge clk);
    end
  endtask

  task automatic t_kicks;
    repeat (2300) @(negedge clk);
    chk(kicks == 3, "R8 pulse count", kicks, 3);
    for (int i = 1; i < 3; i++) begin
      int d = ktime[i] - ktime[i-1];
      chk(d >= PER - FRAME && d <= PER + FRAME, "R8 pulse spacing", d, PER);
    end
    chk(viol == 0, "R9 single column low", viol, 0);
  endtask

  task automatic t_press_rel(input int r, input int c);
    bit got; logic [5:0] code;
    setkey(r, c, 1);
    wait_ev(400, got, code);
    chk(got && code == {1'b1, 2'(r), 3'(c)}, "R3 R4 press code", int'(code), int'({1'b1, 2'(r), 3'(c)}));
    setkey(r, c, 0);
    wait_ev(400, got, code);
    chk(got && code == {1'b0, 2'(r), 3'(c)}, "R5 release code", int'(code), int'({1'b0, 2'(r), 3'(c)}));
  endtask

  task automatic t_glitch;
    int n0;
    n0 = nlog;
    setkey(1, 3, 1);
    repeat (100) @(negedge clk);
    setkey(1, 3, 0);
    repeat (400) @(negedge clk);
    chk(nlog == n0, "R4 short press ignored", nlog - n0, 0);
  endtask

  task automatic t_multi;
    int n0;
    n0 = nlog;
    @(posedge clk); #1 keys[0][0] = 1; keys[1][1] = 1;
    repeat (400) @(negedge clk);
    chk(nlog == n0, "R7 two keys ignored", nlog - n0, 0);
    @(posedge clk); #1 keys[0][0] = 0; keys[1][1] = 0;
    repeat (400) @(negedge clk);
    chk(nlog == n0, "R7 no event after release", nlog - n0, 0);
  endtask

  task automatic t_change;
    bit got; logic [5:0] code;
    setkey(0, 1, 1);
    wait_ev(400, got, code);
    chk(got && code == 6'b1_00_001, "R6 first press", int'(code), 6'b1_00_001);
    @(posedge clk); #1 keys[1][0] = 0; keys[4][2] = 1;
    wait_ev(400, got, code);
    chk(got && code == 6'b0_00_001, "R6 old key released", int'(code), 6'b0_00_001);
    wait_ev(400, got, code);
    chk(got && code == 6'b1_10_100, "R6 new key pressed", int'(code), 6'b1_10_100);
    setkey(2, 4, 0);
    wait_ev(400, got, code);
    chk(got && code == 6'b0_10_100, "R5 new key released", int'(code), 6'b0_10_100);
  endtask

  task automatic t_stall;
    bit got; logic [5:0] code; int n0;
    @(posedge clk); #1 ev_ready = 1'b0;
    setkey(1, 4, 1);
    repeat (400) @(negedge clk);
    chk(ev_valid && ev_code == 6'b1_01_100, "R11 pending press", int'(ev_code), 6'b1_01_100);
    setkey(1, 4, 0);
    repeat (400) @(negedge clk);
    chk(ev_valid && ev_code == 6'b1_01_100, "R11 press held under stall", int'(ev_code), 6'b1_01_100);
    n0 = nlog;
    @(posedge clk); #1 ev_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(nlog == n0 + 1 && evlog[n0[7:0]] == 6'b1_01_100, "R11 held press delivered", int'(evlog[n0[7:0]]), 6'b1_01_100);
    wait_ev(400, got, code);
    chk(got && code == 6'b0_01_100, "R11 late release delivered", int'(code), 6'b0_01_100);
  endtask

  task automatic t_pwr_off;
    int k0;
    @(posedge clk); #1 pwr_off = 1'b1;
    repeat (100) @(negedge clk);
    k0 = kicks;
    repeat (1700) @(negedge clk);
    chk(kicks == k0, "R10 no pulses after power-off", kicks - k0, 0);
    t_press_rel(0, 1);
    chk(viol == 0, "R9 single column low overall", viol, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_scan();
    t_kicks();
    t_press_rel(0, 0);
    t_press_rel(2, 2);
    t_glitch();
    t_multi();
    t_change();
    t_stall();
    t_pwr_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule